// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked system and an external asynchronous static RAM of 128K words by 16 bits. The RAM has active-low chip select, output enable, write enable and two byte-lane selects. A client posts one request at a time through a valid/ready handshake: a read or a write, a 17-bit word address, 16 bits of write data and a two-bit byte-enable mask. The block then drives the RAM pins through a fixed sequence. Each phase is held for a number of clock cycles derived from nanosecond parameters and the clock period, so every minimum pulse, cycle and setup time of the part is met.

Reads finish with a one-cycle response strobe that carries the captured word. After every read the data bus stays undriven for a turnaround window, because the RAM may still be driving it. Writes keep the bus driven for one cycle after write enable rises, which covers the data hold time. The data bus appears as separate output, input and drive-enable signals, so a pad ring can build the tri-state buffer.

Cycle counts are computed as ceil(ns / clock period), with a minimum of 1. At the default 4 ns clock they are:

| Count | Cycles | How it is derived |
|-------|--------|-------------------|
| Read | 22 | from 85 ns |
| Write strobe | 19 | largest of the 60/75/70/75/35 ns write limits |
| Write recovery | 3 | 85 ns write cycle minus the strobe, at least 1 |
| Turnaround | 8 | from 30 ns |

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever idle, `req_ready` is 1 and the RAM is left alone. Chip select, output enable, write enable and both lane selects are high (inactive), `sram_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A read accepted on a clock edge drives chip select and output enable low with write enable high. This starts on that same edge and lasts exactly the read count of cycles.
- R3: During an access, lane select bit i is low exactly when `req_be[i]` was 1 at acceptance. Bit 0 is the low byte, data bits 7:0. Bit 1 is the high byte, data bits 15:8. A write changes only the enabled lanes of the addressed word.
- R4: A read's data is sampled on the edge that ends its last counted cycle and appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle. Bits of lanes that were not enabled read as 0.
- R5: An accepted write holds chip select and write enable low, and output enable high, for exactly the write-strobe count. During that time `sram_dq_o` carries the request's write data and `sram_dq_oe` is 1.
- R6: The data drive stays on for exactly one cycle after write enable rises, then turns off. The write keeps `req_ready` low for the write-strobe plus recovery count in total.
- R7: After a read, `sram_dq_oe` stays 0 and `req_ready` stays low for exactly the turnaround count of cycles after output enable rises. A write that is held waiting therefore starts driving the bus turnaround+1 cycles after output enable rises.
- R8: A request is accepted only on an edge where `req_ready` is 1. Request inputs that change while busy do not affect the RAM address, lanes or data of the access in progress.
- R9: Write enable and output enable are never low together, and the controller never drives the bus while output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 17 | RAM address pins |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_bs_n | output | 2 | RAM lane selects, active low, bit 0 = low byte |
| sram_dq_o | output | 16 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_i | input | 16 | Data returned from the RAM pads |

## Verification
The bench measures each phase length in cycles and compares it with its own ceiling arithmetic. A counter that is one cycle off would shorten the write strobe or the read below the part's minimum, or return data a cycle early. It chains a read straight into a held write and measures the gap from the output enable rising to the first bus drive, which catches a design that drives the bus while the RAM may still be driving it. Byte-lane writes followed by full-word reads expose a lane swap or a missing mask, which would corrupt the neighbouring byte. Reads with partial masks expose unmasked garbage in the response. Request lines scrambled while busy expose a design that does not latch the request.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and cycle arithmetic for the asynchronous RAM sequencer.
// Assumes all timing values are non-negative integers in nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WRITE,
        ST_WREC
    } seq_state_t;

    // Cycles needed to cover ns at the given clock period, never below one.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
// Phase timer: loads a count and counts down to zero, flagging done at zero.
// Assumes a load is only issued when a phase begins.
module sram_ctrl_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Count down the current phase, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
// Access sequencer: steps idle -> read -> turnaround or idle -> write -> recovery.
// It drives the RAM control strobes from flops so the pins do not glitch.
// Assumes the timer reports done on the last cycle of each loaded phase.
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int RD_CYC  = 22,
    parameter int WP_CYC  = 19,
    parameter int REC_CYC = 3,
    parameter int TA_CYC  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             lanes_on,
    output logic             dq_oe,
    output logic             rsp_valid
);
    seq_state_t st, nxt;

    // Choose the next phase and the timer value that phase needs.
    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_IDLE: if (req_valid) begin
                nxt      = req_write ? ST_WRITE : ST_READ;
                tmr_load = 1'b1;
                tmr_val  = req_write ? CNT_W'(WP_CYC - 1) : CNT_W'(RD_CYC - 1);
            end
            ST_READ: if (tmr_done) begin
                nxt      = ST_TURN;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(TA_CYC - 1);
            end
            ST_WRITE: if (tmr_done) begin
                nxt      = ST_WREC;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(REC_CYC - 1);
            end
            ST_TURN, ST_WREC: if (tmr_done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (st == ST_READ) && tmr_done;

    // Register the state and the pin strobes decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cs_n      <= 1'b1;
            oe_n      <= 1'b1;
            we_n      <= 1'b1;
            lanes_on  <= 1'b0;
            dq_oe     <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            st        <= nxt;
            cs_n      <= !((nxt == ST_READ) || (nxt == ST_WRITE));
            oe_n      <= (nxt != ST_READ);
            we_n      <= (nxt != ST_WRITE);
            lanes_on  <= (nxt == ST_READ) || (nxt == ST_WRITE);
            dq_oe     <= (nxt == ST_WRITE) || ((nxt == ST_WREC) && (st == ST_WRITE));
            rsp_valid <= capture;
        end
    end
endmodule

// File: rtl/sram_ctrl_datapath.sv
// Request latches and read capture. Holds the address, data and lane mask
// for the whole access and masks disabled lanes out of the returned word.
// Assumes DATA_W is a whole number of bytes.
module sram_ctrl_datapath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              lanes_on,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] sram_dq_i,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic [LANES-1:0]  sram_bs_n,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] lane_mask;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
    end

    // Latch the request on acceptance so later changes on the inputs are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr <= '0;
            sram_dq_o <= '0;
            be_q      <= '0;
        end else if (accept) begin
            sram_addr <= req_addr;
            sram_dq_o <= req_wdata;
            be_q      <= req_be;
        end
    end

    // Capture the bus on the last read cycle, keeping only enabled lanes.
    always_ff @(posedge clk) begin
        if (!rst_n)       rsp_rdata <= '0;
        else if (capture) rsp_rdata <= sram_dq_i & lane_mask;
    end

    assign sram_bs_n = ~(be_q & {LANES{lanes_on}});
endmodule

// File: rtl/sram_async_ctrl.sv
// Top of the asynchronous static RAM sequencer. It turns single handshaked
// read/write requests into RAM pin sequences timed in whole clock cycles.
// Assumes one outstanding request and a pad ring that builds the tri-state
// buffer from sram_dq_o / sram_dq_oe / sram_dq_i.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_RC_NS       = 85,
    parameter int T_AA_NS       = 85,
    parameter int T_WC_NS       = 85,
    parameter int T_WP_NS       = 60,
    parameter int T_AW_NS       = 75,
    parameter int T_CW_NS       = 70,
    parameter int T_BW_NS       = 75,
    parameter int T_DW_NS       = 35,
    parameter int T_TURN_NS     = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W/8-1:0] sram_bs_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);
    localparam int LANES   = DATA_W / 8;
    localparam int RD_CYC  = imax(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(T_AA_NS, CLK_PERIOD_NS));
    localparam int WP_CYC  = imax(imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                       ns_to_cyc(T_AW_NS, CLK_PERIOD_NS)),
                                  imax(imax(ns_to_cyc(T_CW_NS, CLK_PERIOD_NS),
                                            ns_to_cyc(T_BW_NS, CLK_PERIOD_NS)),
                                       ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)));
    localparam int REC_CYC = imax(1, ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - WP_CYC);
    localparam int TA_CYC  = ns_to_cyc(T_TURN_NS, CLK_PERIOD_NS);
    localparam int CNT_MAX = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, TA_CYC));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             accept, capture, tmr_load, tmr_done, lanes_on;
    logic [CNT_W-1:0] tmr_val;

    sram_ctrl_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    sram_ctrl_fsm #(
        .CNT_W(CNT_W), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC),
        .REC_CYC(REC_CYC), .TA_CYC(TA_CYC)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .tmr_done(tmr_done), .req_ready(req_ready), .accept(accept),
        .capture(capture), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .cs_n(sram_cs_n), .oe_n(sram_oe_n), .we_n(sram_we_n),
        .lanes_on(lanes_on), .dq_oe(sram_dq_oe), .rsp_valid(rsp_valid)
    );

    sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .lanes_on(lanes_on), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .sram_dq_i(sram_dq_i), .sram_addr(sram_addr),
        .sram_dq_o(sram_dq_o), .sram_bs_n(sram_bs_n), .rsp_rdata(rsp_rdata)
    );
endmodule

// File: rtl/sram_ctrl_checker.sv
// Protocol checker for the RAM sequencer, bound to the top module.
// Phase windows are measured with counters rather than long delays.
module sram_ctrl_checker
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_WP_NS       = 60,
    parameter int T_AW_NS       = 75,
    parameter int T_CW_NS       = 70,
    parameter int T_BW_NS       = 75,
    parameter int T_DW_NS       = 35,
    parameter int T_TURN_NS     = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_cs_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              sram_dq_oe
);
    localparam int WP_CYC = imax(imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                      ns_to_cyc(T_AW_NS, CLK_PERIOD_NS)),
                                 imax(imax(ns_to_cyc(T_CW_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_BW_NS, CLK_PERIOD_NS)),
                                      ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)));
    localparam int TA_CYC = ns_to_cyc(T_TURN_NS, CLK_PERIOD_NS);

    logic [15:0] wlow_cnt;
    logic [15:0] oe_off_cnt;

    // Length of the current write-enable low pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                  wlow_cnt <= '0;
        else if (sram_we_n)          wlow_cnt <= '0;
        else if (wlow_cnt != 16'hFFFF) wlow_cnt <= wlow_cnt + 1'b1;
    end

    // Cycles since output enable was last low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                      oe_off_cnt <= 16'hFFFF;
        else if (!sram_oe_n)             oe_off_cnt <= '0;
        else if (oe_off_cnt != 16'hFFFF) oe_off_cnt <= oe_off_cnt + 1'b1;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe));

    assert_rsp_ends_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(sram_oe_n));

    assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (wlow_cnt == 16'(WP_CYC)));

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_oe);

    assert_drive_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && sram_we_n) |=> !sram_dq_oe);

    assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (oe_off_cnt >= 16'(TA_CYC)));

    assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_cs_n) |-> $past(req_ready));

    assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    assert_no_we_with_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    assert_no_drive_into_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);
endmodule

bind sram_async_ctrl sram_ctrl_checker #(
    .ADDR_W(ADDR_W), .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_WP_NS(T_WP_NS),
    .T_AW_NS(T_AW_NS), .T_CW_NS(T_CW_NS), .T_BW_NS(T_BW_NS),
    .T_DW_NS(T_DW_NS), .T_TURN_NS(T_TURN_NS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_dq_oe(sram_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
// Directed bench: a behavioural RAM model plus one task per scenario.
module test_sram_async_ctrl;
    localparam int CLK_NS = 4;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int RD  = cyc(85);
    localparam int WP  = cyc(75);
    localparam int REC = (cyc(85) - WP < 1) ? 1 : cyc(85) - WP;
    localparam int TA  = cyc(30);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [16:0] sram_addr;
    logic        sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [1:0]  sram_bs_n;
    logic [15:0] sram_dq_o, sram_dq_i;

    int n_chk = 0, n_fail = 0;
    logic [15:0] mem [256];
    logic [15:0] exp_mem [256];

    // Per-access measurements filled by run_req.
    int n_busy, n_we, n_oe, n_dqoe, n_rsp, n_turn, e_addr, e_bs, e_data, e_both;
    logic [15:0] got;

    always #(CLK_NS/2) clk = ~clk;

    sram_async_ctrl i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_bs_n(sram_bs_n), .sram_dq_o(sram_dq_o),
        .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    // RAM model: enabled lanes drive stored data, others return a garbage pattern.
    always_comb begin
        for (int l = 0; l < 2; l++)
            sram_dq_i[l*8 +: 8] = (!sram_cs_n && !sram_oe_n && sram_we_n && !sram_bs_n[l])
                                  ? mem[sram_addr[7:0]][l*8 +: 8] : 8'hA5;
    end

    // RAM model: store enabled lanes while the write strobe is low.
    always @(negedge clk) begin
        if (!sram_cs_n && !sram_we_n && sram_dq_oe)
            for (int l = 0; l < 2; l++)
                if (!sram_bs_n[l]) mem[sram_addr[7:0]][l*8 +: 8] <= sram_dq_o[l*8 +: 8];
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue one request, scramble the inputs once accepted, and measure until idle.
    task automatic run_req(input bit wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
        bit seen_oe = 0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 0; req_write = ~wr; req_addr = 17'h1F0F0; req_wdata = 16'hDEAD; req_be = ~be;
        n_busy = 0; n_we = 0; n_oe = 0; n_dqoe = 0; n_rsp = 0; n_turn = 0;
        e_addr = 0; e_bs = 0; e_data = 0; e_both = 0; got = '0;
        while (!req_ready && n_busy < 1000) begin
            n_busy++;
            if (!sram_we_n) n_we++;
            if (!sram_oe_n) begin n_oe++; seen_oe = 1; end
            else if (seen_oe) n_turn++;
            if (sram_dq_oe) n_dqoe++;
            if (rsp_valid) begin n_rsp++; got = rsp_rdata; end
            if (!sram_cs_n && sram_addr !== a) e_addr++;
            if (!sram_cs_n && sram_bs_n !== ~be) e_bs++;
            if (sram_dq_oe && sram_dq_o !== d) e_data++;
            if ((!sram_we_n && !sram_oe_n) || (sram_dq_oe && !sram_oe_n)) e_both++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1", "ready", req_ready, 1);
        chk("R1", "cs_n/oe_n/we_n", {sram_cs_n, sram_oe_n, sram_we_n}, 3'b111);
        chk("R1", "lane selects", sram_bs_n, 2'b11);
        chk("R1", "dq_oe/rsp_valid", {sram_dq_oe, rsp_valid}, 2'b00);
    endtask

    task automatic t_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
        run_req(1, a, d, be);
        chk("R5", "write strobe cycles", n_we, WP);
        chk("R5", "write data mismatches", e_data, 0);
        chk("R6", "drive cycles", n_dqoe, WP + 1);
        chk("R6", "busy cycles", n_busy, WP + REC);
        chk("R3", "lane select mismatches", e_bs, 0);
        chk("R8", "address mismatches", e_addr, 0);
        chk("R9", "oe low cycles in write", n_oe + e_both, 0);
        for (int l = 0; l < 2; l++)
            if (be[l]) exp_mem[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
    endtask

    task automatic t_read(input logic [16:0] a, input logic [1:0] be);
        logic [15:0] e = exp_mem[a[7:0]] & {{8{be[1]}}, {8{be[0]}}};
        run_req(0, a, 16'h0000, be);
        chk("R2", "read cycles", n_oe, RD);
        chk("R2", "we low in read", n_we, 0);
        chk("R4", "response pulses", n_rsp, 1);
        chk("R4", "read data", got, e);
        chk("R7", "turnaround cycles", n_turn, TA);
        chk("R7", "drive during read", n_dqoe, 0);
        chk("R3", "lane select mismatches", e_bs, 0);
        chk("R8", "address mismatches", e_addr, 0);
    endtask

    // Read followed by a write held valid while busy: measures the bus turnaround.
    task automatic t_back_to_back();
        int idx = 0, oe_rise = -1, dq_rise = -1, early = 0;
        bit prev_oe_n = 1, prev_dq = 0, taken = 0;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 17'h00012; req_be = 2'b11;
        @(negedge clk);
        req_write = 1; req_addr = 17'h00077; req_wdata = 16'h5AC3; req_be = 2'b11;
        while (!(taken && req_ready) && idx < 500) begin
            if (!prev_oe_n && sram_oe_n) oe_rise = idx;
            if (!prev_dq && sram_dq_oe && dq_rise < 0) dq_rise = idx;
            if (!sram_we_n && oe_rise < 0) early++;
            if (!sram_we_n && !taken) begin taken = 1; req_valid = 0; end
            prev_oe_n = sram_oe_n; prev_dq = sram_dq_oe;
            idx++;
            @(negedge clk);
        end
        chk("R7", "oe rise to first drive", dq_rise - oe_rise, TA + 1);
        chk("R8", "write started during read", early, 0);
        exp_mem[8'h77] = 16'h5AC3;
        t_read(17'h00077, 2'b11);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = {8'(i) ^ 8'h3C, 8'(i)};
            exp_mem[i] = {8'(i) ^ 8'h3C, 8'(i)};
        end
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read(17'h10034, 2'b11);
        t_write(17'h00012, 16'hBEEF, 2'b11);
        t_read(17'h00012, 2'b11);
        t_write(17'h10040, 16'h1122, 2'b01);
        t_read(17'h10040, 2'b11);
        t_write(17'h00041, 16'h3344, 2'b10);
        t_read(17'h00041, 2'b11);
        t_read(17'h00012, 2'b01);
        t_read(17'h00012, 2'b10);
        t_read(17'h00050, 2'b00);
        t_back_to_back();
        t_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule